// File: doc/BRIEF.md
# Rotating-Calibration Segmented DAC Decoder

This block turns a 16-bit two's complement audio sample into the switch controls of a segmented current-steering converter. The upper five code bits set how many coarse unit sources are on. The lower eleven bits go out as a fine word that steers a binary divider, and the divider is fed by one further unit source. The analog side has 33 identical physical sources: 31 coarse units, one divider feed and one spare.

A slot pointer walks through the 33 physical sources. It moves on by one every `CAL_PERIOD` clocks, and the source it points at is taken out of service for calibration. The logical units below the slot use the physical source of the same index. Those at or above it shift up by one position, so the spare fills the gap and the output never loses a unit. The decoded controls are captured only when the update strobe is high, so no source is reassigned in the middle of a sample.

Top module: `seg_dac_decoder`

## Requirements
- R1: While the synchronous reset `rst` is high, the slot pointer goes to 0. On the next clock `src_en_o`, `cal_sel_o` and `feed_sel_o` are all zero and `fine_o` is 0.
- R2: The outputs take new values only at the clock edge where `load_i` is high. In every other cycle they hold their values, whatever `sample_i` does.
- R3: The coarse count C is 16 + x[14:11] for a sample x ≥ 0. For x < 0 it is 15 − y[14:11], with y = ~x. Logical units 0 to C−1 are enabled and units C to 30 are off.
- R4: The fine word is x[10:0] for x ≥ 0. For x < 0 it is the bitwise complement of y[10:0].
- R5: Sample 0x0000 gives C = 16 with fine 0x000. Sample 0xFFFF gives C = 15 with fine 0x7FF. Across this step the fine word and exactly one coarse unit (logical unit 15) change.
- R6: The slot pointer counts clocks out of reset. It moves on by one every `CAL_PERIOD` clocks and wraps from 32 back to 0. On a load, `cal_sel_o` becomes one-hot at the slot index current at that edge.
- R7: Logical unit k (0 to 31, where 31 is the divider feed) drives physical source k when k < slot, and source k+1 otherwise. The source under calibration is never enabled. `feed_sel_o` is one-hot at the divider feed's physical index, and that source is always enabled.
- R8: At the extremes, 0x7FFF enables every source except the one under calibration (C = 31, fine 0x7FF). 0x8000 enables only the divider feed (C = 0, fine 0x000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_i | input | 16 | Two's complement sample |
| load_i | input | 1 | Update strobe; captures the decoded controls |
| src_en_o | output | 33 | Per-physical-source switch enable |
| cal_sel_o | output | 33 | One-hot marker of the source under calibration |
| feed_sel_o | output | 33 | One-hot marker of the source feeding the divider |
| fine_o | output | 11 | Fine word to the binary divider |

## Verification
The assertions assume that `rst` is high at time zero and for at least one clock edge, and that `load_i` and `sample_i` are steady around each rising edge. They make no assumption about how often `load_i` is pulsed or how it lines up with slot changes. The bench changes inputs only on falling edges, varies the idle gap between loads so that captures land on many slot values, including slot 32 and the wrap back to 0, and changes `sample_i` while `load_i` is low to check the hold behaviour.

// File: rtl/seg_dac_decoder.sv
module seg_dac_decoder #(
  parameter int CODE_W     = 16,
  parameter int FINE_W     = 11,
  parameter int CAL_PERIOD = 64
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [CODE_W-1:0]               sample_i,
  input  logic                            load_i,
  output logic [(2**(CODE_W-FINE_W)):0]   src_en_o,
  output logic [(2**(CODE_W-FINE_W)):0]   cal_sel_o,
  output logic [(2**(CODE_W-FINE_W)):0]   feed_sel_o,
  output logic [FINE_W-1:0]               fine_o
);
  localparam int COARSE_W = CODE_W - FINE_W;
  localparam int N_LOGIC  = 2**COARSE_W;
  localparam int N_PHYS   = N_LOGIC + 1;
  localparam int SW       = $clog2(N_PHYS);
  localparam int CW       = $clog2(CAL_PERIOD + 1);

  logic [CW-1:0]       cnt;
  logic [SW-1:0]       slot;
  logic [COARSE_W-1:0] coarse;
  logic [N_PHYS-1:0]   en_d, cal_d, feed_d;

  // symmetric offset: sign inverted above the magnitude bits, fine bits pass through
  assign coarse = {~sample_i[CODE_W-1], sample_i[CODE_W-2:FINE_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      slot <= '0;
    end else if (cnt == CW'(CAL_PERIOD - 1)) begin
      cnt  <= '0;
      slot <= (slot == SW'(N_PHYS - 1)) ? '0 : slot + 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

  for (genvar p = 0; p < N_PHYS; p++) begin : g_src
    logic [SW-1:0] lidx;
    assign lidx      = (SW'(p) < slot) ? SW'(p) : SW'(p) - 1'b1;
    assign cal_d[p]  = (slot == SW'(p));
    assign feed_d[p] = !cal_d[p] && (lidx == SW'(N_LOGIC - 1));
    assign en_d[p]   = !cal_d[p] && (feed_d[p] || (lidx < SW'(coarse)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_en_o   <= '0;
      cal_sel_o  <= '0;
      feed_sel_o <= '0;
      fine_o     <= '0;
    end else if (load_i) begin
      src_en_o   <= en_d;
      cal_sel_o  <= cal_d;
      feed_sel_o <= feed_d;
      fine_o     <= sample_i[FINE_W-1:0];
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (src_en_o == '0 && cal_sel_o == '0 && feed_sel_o == '0 && fine_o == '0));

  a_r2_hold_without_load: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(src_en_o) && $stable(cal_sel_o) && $stable(feed_sel_o) && $stable(fine_o)));

  a_r3_unit_count: assert property (@(posedge clk) disable iff (rst)
    load_i |=> ($countones(src_en_o) ==
                int'({~$past(sample_i[CODE_W-1]), $past(sample_i[CODE_W-2:FINE_W])}) + 1));

  a_r6_slot_in_range: assert property (@(posedge clk) disable iff (rst)
    slot < SW'(N_PHYS));

  a_r6_slot_wraps: assert property (@(posedge clk) disable iff (rst)
    (slot == SW'(N_PHYS - 1) && cnt == CW'(CAL_PERIOD - 1)) |=> (slot == '0));

  a_r6_cal_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cal_sel_o) && $onehot0(feed_sel_o));

  a_r7_cal_never_enabled: assert property (@(posedge clk) disable iff (rst)
    (cal_sel_o & src_en_o) == '0);

  a_r7_feed_enabled: assert property (@(posedge clk) disable iff (rst)
    (feed_sel_o & ~src_en_o) == '0);
endmodule

// File: tb/test_seg_dac_decoder.sv
module test_seg_dac_decoder;
  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] sample = '0;
  logic        load = 1'b0;
  logic [32:0] src_en, cal_sel, feed_sel;
  logic [10:0] fine;

  int checks = 0;
  int errors = 0;
  int ncyc   = 0;

  seg_dac_decoder #(.CAL_PERIOD(P)) i_seg_dac_decoder (
    .clk(clk), .rst(rst), .sample_i(sample), .load_i(load),
    .src_en_o(src_en), .cal_sel_o(cal_sel), .feed_sel_o(feed_sel), .fine_o(fine)
  );

  always #5 clk = ~clk;

  always @(posedge clk) if (rst) ncyc <= 0; else ncyc <= ncyc + 1;

  localparam logic [15:0] VEC [12] = '{
    16'h0000, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h0800, 16'hF7FF,
    16'h1234, 16'hEDCB, 16'h4000, 16'hC000, 16'h07FF, 16'hF800
  };

  function automatic int exp_coarse(input logic [15:0] x);
    logic [15:0] y;
    y = ~x;
    if (x[15]) return 15 - int'(y[14:11]);
    return 16 + int'(x[14:11]);
  endfunction

  function automatic logic [10:0] exp_fine(input logic [15:0] x);
    logic [15:0] y;
    y = ~x;
    if (x[15]) return ~y[10:0];
    return x[10:0];
  endfunction

  function automatic logic [32:0] exp_en(input logic [15:0] x, input int s);
    logic [32:0] v;
    int c;
    c = exp_coarse(x);
    v = '0;
    for (int p = 0; p < 33; p++) begin
      int l;
      if (p == s) continue;
      l = (p < s) ? p : p - 1;
      v[p] = (l == 31) || (l < c);
    end
    return v;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [15:0] x, input string req);
    int s;
    @(negedge clk);
    sample = x;
    load = 1'b1;
    s = (ncyc / P) % 33;
    @(negedge clk);
    load = 1'b0;
    check({req, " R3/R7 enables"}, 64'(src_en), 64'(exp_en(x, s)));
    check({req, " R4 fine"}, 64'(fine), 64'(exp_fine(x)));
    check({req, " R6 cal marker"}, 64'(cal_sel), 64'(33'b1 << s));
    check({req, " R7 feed marker"}, 64'(feed_sel), 64'(33'b1 << ((s == 32) ? 31 : 32)));
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 enables", 64'(src_en), 64'd0);
    check("R1 cal", 64'(cal_sel), 64'd0);
    check("R1 feed", 64'(feed_sel), 64'd0);
    check("R1 fine", 64'(fine), 64'd0);
    rst = 1'b0;

    for (int i = 0; i < 12; i++) begin
      repeat (i * 7) @(negedge clk);
      do_load(VEC[i], "table");
    end

    // R6 slots 32 and wrap: advance to slot 32 then to slot 0
    while (((ncyc / P) % 33) != 32) @(negedge clk);
    do_load(16'h2222, "R6 slot32");
    while (((ncyc / P) % 33) != 0) @(negedge clk);
    do_load(16'hDDDD, "R6 wrap slot0");

    // R5 zero crossing
    do_load(16'h0000, "R5 zero");
    check("R5 zero count", 64'($countones(src_en)), 64'd17);
    do_load(16'hFFFF, "R5 minus one");
    check("R5 minus one count", 64'($countones(src_en)), 64'd16);
    check("R5 fine 0x7FF", 64'(fine), 64'h7FF);

    // R8 extremes
    do_load(16'h7FFF, "R8 max");
    check("R8 max all but cal", 64'(src_en | cal_sel), 64'h1_FFFF_FFFF);
    do_load(16'h8000, "R8 min");
    check("R8 min feed only", 64'(src_en), 64'(feed_sel));

    // R2 hold: sample changes with load low across slot steps
    begin
      logic [32:0] e0, c0;
      logic [10:0] f0;
      e0 = src_en; c0 = cal_sel; f0 = fine;
      sample = 16'h5A5A;
      repeat (3 * P) @(negedge clk);
      check("R2 hold enables", 64'(src_en), 64'(e0));
      check("R2 hold cal", 64'(cal_sel), 64'(c0));
      check("R2 hold fine", 64'(fine), 64'(f0));
    end

    // R1 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    check("R1 re-reset enables", 64'(src_en), 64'd0);
    check("R1 re-reset fine", 64'(fine), 64'd0);
    rst = 1'b0;
    do_load(16'h3C3C, "R1 slot restart");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule